// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory DMA Handshake Controller

The block moves a single word from a peripheral data register into memory while the processor carries on with its program. Software first loads a source address and a destination address into two configuration registers. When the peripheral raises its service request, the controller asks the processor for the system bus. Once the processor grants the bus, the controller acknowledges the peripheral, reads the source location and writes the word to the destination location. It then drops its bus request and the peripheral acknowledge in the same cycle. The processor later withdraws the grant and the peripheral withdraws its request.

The bus master port is a synchronous memory-style interface. A read strobe in one cycle returns read data in the following cycle. A write strobe carries address and data in the same cycle. Outside the granted window the port is driven to zero. The source and destination addresses are copied when the controller accepts a request, so a configuration write made during a transfer affects only later transfers.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After synchronous reset, every output is 0: bus request, peripheral acknowledge, read strobe, write strobe, address and write data.
- R2: In the cycle after the peripheral request is sampled high while idle, the bus request goes high. The peripheral acknowledge stays low at that point.
- R3: While the bus request is high and the grant is low, the peripheral acknowledge, read strobe and write strobe all stay low, however long the grant is delayed.
- R4: In the cycle after the grant is sampled high, the peripheral acknowledge goes high. In that same cycle the read strobe is asserted with the configured source address on the address output.
- R5: The cycle after the read is a capture cycle with neither strobe set. The cycle after that asserts the write strobe with the destination address and the word returned by the read.
- R6: In the cycle after the write, the bus request and the peripheral acknowledge fall together. No strobe is active in that cycle.
- R7: After a transfer, no new bus request is raised until both the grant and the peripheral request have been sampled low.
- R8: A configuration write (select 0 = source, 1 = destination) made after a request has been accepted does not change the addresses used by that transfer. It does apply to the next transfer.
- R9: Address and write data outputs are 0 whenever no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | Configuration target: 0 source address, 1 destination address |
| cfg_wdata | input | AW | Configuration write value |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Acknowledge to peripheral |
| bus_req | output | 1 | Bus request to processor |
| bus_grant | input | 1 | Bus grant from processor |
| mem_rd | output | 1 | Bus read strobe |
| mem_wr | output | 1 | Bus write strobe |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Bus read data, valid the cycle after the read strobe |

## Verification
Every response is registered, so each result appears exactly one clock after the input that causes it. The bus request follows the request, the acknowledge and read follow the grant, the write follows two cycles after the read, and the joint release follows one cycle after the write. The bench drives inputs on falling edges. It then checks the outputs at the next falling edge, half a period after the rising edge that updated them, and repeats that check on each cycle of a delayed grant. The memory model returns read data one cycle after the strobe, matching the capture cycle.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BUSREQ = 3'd1,
        ST_READ   = 3'd2,
        ST_CAPT   = 3'd3,
        ST_WRITE  = 3'd4,
        ST_DRAIN  = 3'd5
    } hs_state_e;

    typedef struct packed {
        logic bus_req;
        logic per_ack;
        logic rd;
        logic wr;
    } hs_ctrl_t;

    localparam logic CFG_SEL_SRC = 1'b0;
    localparam logic CFG_SEL_DST = 1'b1;

    function automatic hs_ctrl_t decode_ctrl(input hs_state_e st);
        hs_ctrl_t c;
        c = '0;
        case (st)
            ST_BUSREQ: c.bus_req = 1'b1;
            ST_READ:   begin c.bus_req = 1'b1; c.per_ack = 1'b1; c.rd = 1'b1; end
            ST_CAPT:   begin c.bus_req = 1'b1; c.per_ack = 1'b1; end
            ST_WRITE:  begin c.bus_req = 1'b1; c.per_ack = 1'b1; c.wr = 1'b1; end
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dma_cfg_bank.sv
module dma_cfg_bank #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] src_cfg,
    output logic [AW-1:0] dst_cfg
);
    import dma_xfer_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_cfg <= '0;
            dst_cfg <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == CFG_SEL_SRC) src_cfg <= cfg_wdata;
            else                        dst_cfg <= cfg_wdata;
        end
    end

endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   per_req,
    input  logic                   bus_grant,
    input  logic [AW-1:0]          src_cfg,
    input  logic [AW-1:0]          dst_cfg,
    input  logic [DW-1:0]          rdata,
    output dma_xfer_pkg::hs_ctrl_t ctrl,
    output logic [AW-1:0]          src_act,
    output logic [AW-1:0]          dst_act,
    output logic [DW-1:0]          word_q
);
    import dma_xfer_pkg::*;

    hs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (per_req) state_d = ST_BUSREQ;
            ST_BUSREQ: if (bus_grant) state_d = ST_READ;
            ST_READ:   state_d = ST_CAPT;
            ST_CAPT:   state_d = ST_WRITE;
            ST_WRITE:  state_d = ST_DRAIN;
            ST_DRAIN:  if (!bus_grant && !per_req) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            src_act <= '0;
            dst_act <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && per_req) begin
                src_act <= src_cfg;
                dst_act <= dst_cfg;
            end
            if (state_q == ST_CAPT) word_q <= rdata;
        end
    end

    assign ctrl = decode_ctrl(state_q);

    // R3
    ack_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.per_ack) |-> $past(bus_grant));

    // R5
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.wr |-> $past(ctrl.rd, 2));

    // R6
    joint_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.bus_req) |-> $fell(ctrl.per_ack));

    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.bus_req) |-> !$past(bus_grant));

endmodule

// File: rtl/dma_bus_port.sv
module dma_bus_port #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  dma_xfer_pkg::hs_ctrl_t ctrl,
    input  logic                   bus_grant,
    input  logic [AW-1:0]          src_act,
    input  logic [AW-1:0]          dst_act,
    input  logic [DW-1:0]          word_q,
    output logic                   mem_rd,
    output logic                   mem_wr,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata
);
    logic own;
    assign own = bus_grant & ctrl.per_ack;

    always_comb begin
        mem_rd    = own & ctrl.rd;
        mem_wr    = own & ctrl.wr;
        mem_addr  = '0;
        mem_wdata = '0;
        if (mem_rd) mem_addr = src_act;
        if (mem_wr) begin
            mem_addr  = dst_act;
            mem_wdata = word_q;
        end
    end

    // R4
    rd_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (ctrl.per_ack && ctrl.bus_req));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd || mem_wr) |-> (mem_addr == '0 && mem_wdata == '0));

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          per_req,
    output logic          per_ack,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    import dma_xfer_pkg::*;

    logic [AW-1:0] src_cfg, dst_cfg, src_act, dst_act;
    logic [DW-1:0] word_q;
    hs_ctrl_t      ctrl;

    dma_cfg_bank #(.AW(AW)) cfg_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .src_cfg(src_cfg), .dst_cfg(dst_cfg)
    );

    dma_hs_fsm #(.AW(AW), .DW(DW)) fsm_i (
        .clk(clk), .rst(rst), .per_req(per_req), .bus_grant(bus_grant),
        .src_cfg(src_cfg), .dst_cfg(dst_cfg), .rdata(mem_rdata),
        .ctrl(ctrl), .src_act(src_act), .dst_act(dst_act), .word_q(word_q)
    );

    dma_bus_port #(.AW(AW), .DW(DW)) port_i (
        .clk(clk), .rst(rst), .ctrl(ctrl), .bus_grant(bus_grant),
        .src_act(src_act), .dst_act(dst_act), .word_q(word_q),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    assign bus_req = ctrl.bus_req;
    assign per_ack = ctrl.per_ack;

endmodule

// File: tb/dma_xfer_ctrl_tb.sv
module dma_xfer_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;

    typedef struct packed {
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] val;
        logic [3:0]  dly;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{src:16'h8000, dst:16'h0001, val:16'h5A3C, dly:4'd0},
        '{src:16'h8004, dst:16'h0100, val:16'hFFFF, dly:4'd3},
        '{src:16'hC000, dst:16'h7FFE, val:16'h0000, dly:4'd1},
        '{src:16'h0002, dst:16'hFFFF, val:16'h1234, dly:4'd7}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic per_req = 1'b0, bus_grant = 1'b0;
    logic per_ack, bus_req, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] exp_src = '0;
    logic [DW-1:0] exp_val = '0;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk)
        if (mem_rd) mem_rdata <= (mem_addr == exp_src) ? exp_val : 16'hDEAD;

    dma_xfer_ctrl #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .per_req(per_req), .per_ack(per_ack),
        .bus_req(bus_req), .bus_grant(bus_grant), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [AW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one transfer; cfg_mid lets a config write land while the bus is requested.
    task automatic run_xfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                            input logic [DW-1:0] val, input int dly, input bit cfg_mid);
        exp_src = src; exp_val = val;
        @(negedge clk); per_req = 1'b1;
        @(negedge clk);
        chk("R2 bus_req", {31'd0, bus_req}, 32'd1);
        chk("R2 per_ack", {31'd0, per_ack}, 32'd0);
        if (cfg_mid) begin
            cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h4321;
            @(negedge clk); cfg_we = 1'b0;
        end
        for (int i = 0; i < dly; i++) begin
            chk("R3 ack low", {31'd0, per_ack}, 32'd0);
            chk("R3 no strobe", {30'd0, mem_rd, mem_wr}, 32'd0);
            @(negedge clk);
        end
        bus_grant = 1'b1;
        @(negedge clk);
        chk("R4 per_ack", {31'd0, per_ack}, 32'd1);
        chk("R4 mem_rd", {31'd0, mem_rd}, 32'd1);
        chk("R4/R8 src addr", {16'd0, mem_addr}, {16'd0, src});
        @(negedge clk);
        chk("R5 capture quiet", {30'd0, mem_rd, mem_wr}, 32'd0);
        chk("R9 addr zero", {16'd0, mem_addr}, 32'd0);
        @(negedge clk);
        chk("R5 mem_wr", {31'd0, mem_wr}, 32'd1);
        chk("R5 dst addr", {16'd0, mem_addr}, {16'd0, dst});
        chk("R5 wdata", {16'd0, mem_wdata}, {16'd0, val});
        @(negedge clk);
        chk("R6 joint release", {30'd0, bus_req, per_ack}, 32'd0);
        chk("R6 no strobe", {30'd0, mem_rd, mem_wr}, 32'd0);
        @(negedge clk);
        chk("R7 grant+req high", {31'd0, bus_req}, 32'd0);
        bus_grant = 1'b0;
        @(negedge clk);
        chk("R7 req still high", {31'd0, bus_req}, 32'd0);
        per_req = 1'b0;
        @(negedge clk);
        chk("R7 idle", {31'd0, bus_req}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", {28'd0, bus_req, per_ack, mem_rd, mem_wr}, 32'd0);
        chk("R1 bus", {mem_addr, mem_wdata}, 32'd0);
        rst = 1'b0;

        for (int v = 0; v < 4; v++) begin
            cfg_write(1'b0, VECS[v].src);
            cfg_write(1'b1, VECS[v].dst);
            run_xfer(VECS[v].src, VECS[v].dst, VECS[v].val, int'(VECS[v].dly), 1'b0);
        end

        // R8: source rewritten during request; current transfer keeps old, next uses new
        cfg_write(1'b0, 16'h9000);
        cfg_write(1'b1, 16'h0042);
        run_xfer(16'h9000, 16'h0042, 16'hBEEF, 2, 1'b1);
        run_xfer(16'h4321, 16'h0042, 16'hCAFE, 0, 1'b0);

        // R9: idle outputs quiet with grant held high and no request
        bus_grant = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R9 idle quiet", {mem_addr, mem_wdata}, 32'd0);
        chk("R7 grant alone", {31'd0, bus_req}, 32'd0);
        bus_grant = 1'b0;

        // R1: reset in mid-transfer clears outputs
        per_req = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_grant = 1'b1;
        @(negedge clk);
        rst = 1'b1; per_req = 1'b0; bus_grant = 1'b0;
        @(negedge clk);
        chk("R1 mid reset", {28'd0, bus_req, per_ack, mem_rd, mem_wr}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule